// File: doc/BRIEF.md
# TCP Server Connection Manager

This block runs the connection-level control of a single server-side TCP connection. It waits passively for a connection request and completes the three-way handshake. It then passes the connection to a separate transmit sequencer and a separate receive sequencer, and stays suspended while they run. When the transmit sequencer signals that it is finished, the block closes the connection from the server side. It answers the client's own close and holds a 2×MSL quiet period before it listens again.

Segments arrive from the lower layer one byte per cycle, qualified by a valid flag and marked at their first byte. Outgoing segments are written one byte per cycle once the lower layer signals ready. Only the 20-byte header is handled: ports, sequence and acknowledgement numbers, the data-offset byte and the flag bits. The block builds no checksum, no options and no window. While the connection is open, the block publishes the peer port, the next send sequence number and the next expected receive sequence number, so that the sequencers can use them.

Top module: `tcpServerConn`

## Requirements
- R1: After reset the block is listening. `txValid`, `txInit` and `rxInit` are low, and `tcbPeerPort`, `tcbSndNxt` and `tcbRcvNxt` read zero.
- R2: While listening, the block discards without reply any segment that is not a connection request. A connection request has SYN set, ACK and RST clear, a destination port equal to `LOCAL_PORT` and a data-offset byte of 0x50. A later valid request is still accepted.
- R3: A connection request is answered by a SYN-ACK segment (flags 0x12). Its source port is `LOCAL_PORT` and its destination port is the client's port. Its acknowledgement number is the client sequence number plus one. Its sequence number is a free-running counter sampled at the request, so it differs between two connections.
- R4: No outgoing segment starts while `txReady` is low. Once `txReady` is seen high, the segment is driven in full.
- R5: If no matching ACK arrives within `SYNACK_TO` cycles after the SYN-ACK, the identical SYN-ACK is sent again. A matching ACK has ACK set, SYN and RST clear, matching ports and an acknowledgement number of server sequence plus one. An ACK with any other acknowledgement number does not complete the handshake.
- R6: A matching handshake ACK raises `txInit` and `rxInit` together for exactly one cycle. The published values then become the client port, server sequence plus one, and client sequence plus one.
- R7: While the connection is handed off, incoming segments produce no output and leave the published values unchanged, until `txResume` is seen.
- R8: On `txResume`, a FIN segment (flags 0x11) is sent. Its sequence number is `resumeSeq` sampled at the resume, and its acknowledgement number is the published receive number.
- R9: If the FIN is not acknowledged (acknowledgement number `resumeSeq`+1) within `FIN_TO` cycles, the identical FIN is sent again.
- R10: After the FIN is acknowledged, a client segment with FIN set and matching ports is answered by an ACK segment (flags 0x10). Its sequence number is `resumeSeq`+1 and its acknowledgement number is the client FIN's sequence number plus one.
- R11: After that ACK, the block ignores all segments for 2×`MSL_CYC` cycles. It then clears the published values to zero and accepts a new connection.
- R12: If no client FIN arrives within `CLIFIN_TO` cycles after the FIN is acknowledged, the block clears the published values and listens again without sending anything.
- R13: Every outgoing segment is 20 bytes on 20 consecutive `txValid` cycles, most significant byte first. Bytes 0–1 are the source port, 2–3 the destination port, 4–7 the sequence number, 8–11 the acknowledgement number, byte 12 is 0x50 and byte 13 holds the flags (FIN bit 0, SYN bit 1, RST bit 2, ACK bit 4). Bytes 14–19 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxData | input | 8 | Incoming segment byte |
| rxValid | input | 1 | `rxData` holds a valid byte |
| rxFirst | input | 1 | Current valid byte is byte 0 of a segment |
| txReady | input | 1 | Lower layer can take a segment |
| txData | output | 8 | Outgoing segment byte |
| txValid | output | 1 | `txData` holds a valid byte |
| txInit | output | 1 | One-cycle start strobe to the transmit sequencer |
| rxInit | output | 1 | One-cycle start strobe to the receive sequencer |
| txResume | input | 1 | Transmit sequencer returns control for closing |
| resumeSeq | input | 32 | Next send sequence number at resume |
| tcbPeerPort | output | 16 | Connected client port |
| tcbSndNxt | output | 32 | Next server send sequence number |
| tcbRcvNxt | output | 32 | Next expected client sequence number |

## Verification
The listen state is tested with segments that have the wrong flags and with segments sent to the wrong port. This shows that classification filters on both. The handshake is tested both with an ACK that carries a wrong acknowledgement number and with a correct one. This separates a real match from a handshake that any ACK would complete. The bench withholds answers to the SYN-ACK, the FIN and the expected client FIN in turn. This drives each of the three timeout exits: two resend the same segment and one drops the connection. A request sent during the hand-off and one sent during the 2×MSL wait both show that segments are ignored in those phases. A second full connection shows that clearing works and that the initial sequence number changes.

// File: rtl/tcpSrvPkg.sv
package tcpSrvPkg;
  localparam int HDR_BYTES = 20;
  localparam int HDR_BITS  = HDR_BYTES * 8;
  localparam int HDR_KEEP  = 14;
  localparam int IDX_W     = $clog2(HDR_BYTES + 1);

  localparam logic [7:0] FL_FIN   = 8'h01;
  localparam logic [7:0] FL_SYN   = 8'h02;
  localparam logic [7:0] FL_RST   = 8'h04;
  localparam logic [7:0] FL_ACK   = 8'h10;
  localparam logic [7:0] DATA_OFF = 8'h50;

  typedef enum logic [1:0] {
    SEG_SYNACK = 2'd0,
    SEG_FIN    = 2'd1,
    SEG_ACK    = 2'd2
  } segKind_t;

  typedef struct packed {
    logic     capSyn;
    logic     capResume;
    logic     capFin;
    logic     advSnd;
    logic     clear;
    logic     sendGo;
    segKind_t kind;
  } dpCtrl_t;

  typedef struct packed {
    logic segDone;
    logic isSynReq;
    logic isAckMatch;
    logic isFin;
  } rxInfo_t;
endpackage

// File: rtl/tcpConnDatapath.sv
module tcpConnDatapath
  import tcpSrvPkg::*;
#(
  parameter logic [15:0] LOCAL_PORT = 16'd80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  dpCtrl_t     ctl,
  output rxInfo_t     rx,
  input  logic [7:0]  rxData,
  input  logic        rxValid,
  input  logic        rxFirst,
  input  logic [31:0] resumeSeq,
  output logic [7:0]  txData,
  output logic        txValid,
  output logic        txBusy,
  output logic        sendDone,
  output logic [15:0] tcbPeerPort,
  output logic [31:0] tcbSndNxt,
  output logic [31:0] tcbRcvNxt
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_BYTES - 1);

  // ---------------- receive parser ----------------
  logic [7:0]       rxHdr [HDR_KEEP];
  logic [IDX_W-1:0] rxIdx, rxPos;
  logic             rxLive, rxTake, rxLast, rxDoneQ;

  assign rxPos  = rxFirst ? '0 : rxIdx;
  assign rxTake = rxValid && (rxFirst || rxLive);
  assign rxLast = rxTake && (rxPos == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxIdx   <= '0;
      rxLive  <= 1'b0;
      rxDoneQ <= 1'b0;
    end else begin
      rxDoneQ <= rxLast;
      if (rxTake) begin
        rxLive <= !rxLast;
        rxIdx  <= rxPos + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < HDR_KEEP; g++) begin : gHdrByte
    always_ff @(posedge clk) begin
      if (!rst_n)
        rxHdr[g] <= '0;
      else if (rxTake && (rxPos == IDX_W'(g)))
        rxHdr[g] <= rxData;
    end
  end

  logic [15:0] inSrcPort, inDstPort;
  logic [31:0] inSeq, inAck;
  logic [7:0]  inFlags;
  logic        hdrOk, portsOk;

  assign inSrcPort = {rxHdr[0], rxHdr[1]};
  assign inDstPort = {rxHdr[2], rxHdr[3]};
  assign inSeq     = {rxHdr[4], rxHdr[5], rxHdr[6], rxHdr[7]};
  assign inAck     = {rxHdr[8], rxHdr[9], rxHdr[10], rxHdr[11]};
  assign inFlags   = rxHdr[13];
  assign hdrOk     = (rxHdr[12] == DATA_OFF) && (inDstPort == LOCAL_PORT);
  assign portsOk   = hdrOk && (inSrcPort == tcbPeerPort);

  logic [31:0] sndNxt, rcvNxt;
  logic [15:0] peerPort;

  assign rx.segDone    = rxDoneQ;
  assign rx.isSynReq   = hdrOk && ((inFlags & (FL_SYN | FL_ACK | FL_RST)) == FL_SYN);
  assign rx.isAckMatch = portsOk && ((inFlags & (FL_SYN | FL_ACK | FL_RST)) == FL_ACK)
                         && (inAck == sndNxt + 32'd1);
  assign rx.isFin      = portsOk && ((inFlags & (FL_FIN | FL_SYN)) == FL_FIN);

  // ---------------- connection variables ----------------
  logic [31:0] isnCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) isnCnt <= '0;
    else        isnCnt <= isnCnt + 32'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ctl.clear) begin
      peerPort <= '0;
      sndNxt   <= '0;
      rcvNxt   <= '0;
    end else begin
      if (ctl.capSyn) begin
        peerPort <= inSrcPort;
        sndNxt   <= isnCnt;
        rcvNxt   <= inSeq + 32'd1;
      end
      if (ctl.capResume) sndNxt <= resumeSeq;
      if (ctl.advSnd)    sndNxt <= sndNxt + 32'd1;
      if (ctl.capFin)    rcvNxt <= inSeq + 32'd1;
    end
  end

  assign tcbPeerPort = peerPort;
  assign tcbSndNxt   = sndNxt;
  assign tcbRcvNxt   = rcvNxt;

  // ---------------- transmit serializer ----------------
  logic [7:0]          outFlags;
  logic [HDR_BITS-1:0] txVec;
  logic [IDX_W-1:0]    txIdx;
  logic                txActive;

  always_comb begin
    case (ctl.kind)
      SEG_SYNACK: outFlags = FL_SYN | FL_ACK;
      SEG_FIN:    outFlags = FL_FIN | FL_ACK;
      default:    outFlags = FL_ACK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txActive <= 1'b0;
      txIdx    <= '0;
      txVec    <= '0;
    end else if (ctl.sendGo) begin
      txActive <= 1'b1;
      txIdx    <= '0;
      txVec    <= {LOCAL_PORT, peerPort, sndNxt, rcvNxt, DATA_OFF, outFlags, 48'h0};
    end else if (txActive) begin
      if (txIdx == LAST_IDX) txActive <= 1'b0;
      txIdx <= txIdx + 1'b1;
    end
  end

  assign txData   = txVec[(HDR_BYTES - 1 - int'(txIdx)) * 8 +: 8];
  assign txValid  = txActive;
  assign txBusy   = txActive;
  assign sendDone = txActive && (txIdx == LAST_IDX);

  // a segment, once begun, continues without a gap until its last byte
  p_burst_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && !sendDone) |=> txValid);
endmodule

// File: rtl/tcpConnCtrl.sv
module tcpConnCtrl
  import tcpSrvPkg::*;
#(
  parameter int unsigned SYNACK_TO = 50000,
  parameter int unsigned FIN_TO    = 50000,
  parameter int unsigned CLIFIN_TO = 100000,
  parameter int unsigned MSL_CYC   = 1000000
) (
  input  logic    clk,
  input  logic    rst_n,
  input  rxInfo_t rx,
  input  logic    txReady,
  input  logic    txBusy,
  input  logic    sendDone,
  input  logic    txResume,
  output dpCtrl_t ctl,
  output logic    txInit,
  output logic    rxInit
);
  localparam int unsigned TW_CYC = 2 * MSL_CYC;
  localparam int unsigned MAX_A  = (SYNACK_TO > FIN_TO) ? SYNACK_TO : FIN_TO;
  localparam int unsigned MAX_B  = (CLIFIN_TO > TW_CYC) ? CLIFIN_TO : TW_CYC;
  localparam int unsigned T_MAX  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int          TMR_W  = $clog2(T_MAX + 1);

  typedef enum logic [2:0] {
    S_LISTEN, S_READY, S_SEND, S_SYNACK_WAIT,
    S_ESTAB, S_FINACK_WAIT, S_CLIFIN_WAIT, S_TIMEWAIT
  } state_t;

  state_t           st, nxt;
  segKind_t         kindQ, kindNxt;
  logic [TMR_W-1:0] tmr, limit;
  logic             inWait, expired, initHit;

  always_comb begin
    inWait = 1'b1;
    case (st)
      S_SYNACK_WAIT: limit = TMR_W'(SYNACK_TO);
      S_FINACK_WAIT: limit = TMR_W'(FIN_TO);
      S_CLIFIN_WAIT: limit = TMR_W'(CLIFIN_TO);
      S_TIMEWAIT:    limit = TMR_W'(TW_CYC);
      default: begin
        limit  = '0;
        inWait = 1'b0;
      end
    endcase
  end

  assign expired = inWait && (tmr == limit - 1'b1);
  assign initHit = (st == S_SYNACK_WAIT) && rx.segDone && rx.isAckMatch;

  always_comb begin
    nxt     = st;
    kindNxt = kindQ;
    ctl     = '0;
    ctl.kind = kindQ;
    case (st)
      S_LISTEN:
        if (rx.segDone && rx.isSynReq) begin
          ctl.capSyn = 1'b1;
          kindNxt    = SEG_SYNACK;
          nxt        = S_READY;
        end
      S_READY:
        if (txReady) begin
          ctl.sendGo = 1'b1;
          nxt        = S_SEND;
        end
      S_SEND:
        if (sendDone) begin
          case (kindQ)
            SEG_SYNACK: nxt = S_SYNACK_WAIT;
            SEG_FIN:    nxt = S_FINACK_WAIT;
            default:    nxt = S_TIMEWAIT;
          endcase
        end
      S_SYNACK_WAIT:
        if (initHit) begin
          ctl.advSnd = 1'b1;
          nxt        = S_ESTAB;
        end else if (expired) begin
          nxt = S_READY;
        end
      S_ESTAB:
        if (txResume) begin
          ctl.capResume = 1'b1;
          kindNxt       = SEG_FIN;
          nxt           = S_READY;
        end
      S_FINACK_WAIT:
        if (rx.segDone && rx.isAckMatch) begin
          ctl.advSnd = 1'b1;
          nxt        = S_CLIFIN_WAIT;
        end else if (expired) begin
          nxt = S_READY;
        end
      S_CLIFIN_WAIT:
        if (rx.segDone && rx.isFin) begin
          ctl.capFin = 1'b1;
          kindNxt    = SEG_ACK;
          nxt        = S_READY;
        end else if (expired) begin
          ctl.clear = 1'b1;
          nxt       = S_LISTEN;
        end
      S_TIMEWAIT:
        if (expired) begin
          ctl.clear = 1'b1;
          nxt       = S_LISTEN;
        end
      default: nxt = S_LISTEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_LISTEN;
      kindQ  <= SEG_SYNACK;
      tmr    <= '0;
      txInit <= 1'b0;
      rxInit <= 1'b0;
    end else begin
      st     <= nxt;
      kindQ  <= kindNxt;
      txInit <= initHit;
      rxInit <= initHit;
      if (nxt != st)   tmr <= '0;
      else if (inWait) tmr <= tmr + 1'b1;
    end
  end

  // nothing is being sent while the block sits listening
  p_listen_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LISTEN) |-> !txBusy);

  // the handshake wait never outlasts its timeout
  p_synack_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SYNACK_WAIT) |-> (32'(tmr) < SYNACK_TO));

  // the hand-off holds until the transmitter resumes
  p_estab_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ESTAB && !txResume) |=> (st == S_ESTAB));
endmodule

// File: rtl/tcpServerConn.sv
module tcpServerConn
  import tcpSrvPkg::*;
#(
  parameter logic [15:0] LOCAL_PORT = 16'd80,
  parameter int unsigned SYNACK_TO  = 50000,
  parameter int unsigned FIN_TO     = 50000,
  parameter int unsigned CLIFIN_TO  = 100000,
  parameter int unsigned MSL_CYC    = 1000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  rxData,
  input  logic        rxValid,
  input  logic        rxFirst,
  input  logic        txReady,
  output logic [7:0]  txData,
  output logic        txValid,
  output logic        txInit,
  output logic        rxInit,
  input  logic        txResume,
  input  logic [31:0] resumeSeq,
  output logic [15:0] tcbPeerPort,
  output logic [31:0] tcbSndNxt,
  output logic [31:0] tcbRcvNxt
);
  dpCtrl_t ctl;
  rxInfo_t rxInfo;
  logic    txBusy, sendDone;

  tcpConnCtrl #(
    .SYNACK_TO(SYNACK_TO), .FIN_TO(FIN_TO),
    .CLIFIN_TO(CLIFIN_TO), .MSL_CYC(MSL_CYC)
  ) uCtrl (
    .clk(clk), .rst_n(rst_n), .rx(rxInfo), .txReady(txReady),
    .txBusy(txBusy), .sendDone(sendDone), .txResume(txResume),
    .ctl(ctl), .txInit(txInit), .rxInit(rxInit)
  );

  tcpConnDatapath #(.LOCAL_PORT(LOCAL_PORT)) uDp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .rx(rxInfo),
    .rxData(rxData), .rxValid(rxValid), .rxFirst(rxFirst),
    .resumeSeq(resumeSeq), .txData(txData), .txValid(txValid),
    .txBusy(txBusy), .sendDone(sendDone), .tcbPeerPort(tcbPeerPort),
    .tcbSndNxt(tcbSndNxt), .tcbRcvNxt(tcbRcvNxt)
  );

  // a segment only starts after the lower layer showed ready
  p_send_after_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txValid) |-> $past(txReady));

  // the start strobe to the sequencers lasts a single cycle
  p_init_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    txInit |=> !txInit);
endmodule

// File: tb/tb_tcpServerConn.sv
module tb_tcpServerConn;
  localparam logic [15:0] LPORT   = 16'h0050;
  localparam logic [15:0] CPORT   = 16'hC351;
  localparam logic [15:0] CPORT2  = 16'hD00D;
  localparam int          SA_TO   = 400;
  localparam int          FN_TO   = 300;
  localparam int          CF_TO   = 300;
  localparam int          MSL     = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxValid = 1'b0, rxFirst = 1'b0, txReady = 1'b1;
  logic        txResume = 1'b0;
  logic [31:0] resumeSeq = '0;
  logic [7:0]  txData;
  logic        txValid, txInit, rxInit;
  logic [15:0] tcbPeerPort;
  logic [31:0] tcbSndNxt, tcbRcvNxt;

  always #10 clk = ~clk;

  tcpServerConn #(
    .LOCAL_PORT(LPORT), .SYNACK_TO(SA_TO), .FIN_TO(FN_TO),
    .CLIFIN_TO(CF_TO), .MSL_CYC(MSL)
  ) dut (
    .clk(clk), .rst_n(rst_n), .rxData(rxData), .rxValid(rxValid),
    .rxFirst(rxFirst), .txReady(txReady), .txData(txData),
    .txValid(txValid), .txInit(txInit), .rxInit(rxInit),
    .txResume(txResume), .resumeSeq(resumeSeq),
    .tcbPeerPort(tcbPeerPort), .tcbSndNxt(tcbSndNxt), .tcbRcvNxt(tcbRcvNxt)
  );

  int nChk = 0, nFail = 0, segCount = 0, initCnt = 0, initSplit = 0;
  bit done = 1'b0;
  logic [159:0] expV[$], expM[$];
  string        expTag[$];
  logic [159:0] curSeg = '0, lastSeg = '0;
  int           curN = 0;

  function automatic logic [159:0] mkSeg(input logic [15:0] src, dst,
      input logic [31:0] seq, ack, input logic [7:0] flags);
    return {src, dst, seq, ack, 8'h50, flags, 48'h0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expectSeg(input logic [159:0] v, m, input string tag);
    expV.push_back(v);
    expM.push_back(m);
    expTag.push_back(tag);
  endtask

  // monitor: assembles each outgoing segment and scores it
  always @(negedge clk) begin
    if (rst_n) begin
      if (txInit) initCnt++;
      if (txInit != rxInit) initSplit++;
      if (txValid) begin
        curSeg = {curSeg[151:0], txData};
        curN++;
        if (curN == 20) begin
          logic [159:0] v, m;
          string t;
          segCount++;
          lastSeg = curSeg;
          curN = 0;
          nChk++;
          if (expV.size() == 0) begin
            nFail++;
            $display("FAIL R2/R7/R11 unexpected segment actual=%0h expected=none", curSeg);
          end else begin
            v = expV.pop_front();
            m = expM.pop_front();
            t = expTag.pop_front();
            if (((curSeg ^ v) & m) != '0) begin
              nFail++;
              $display("FAIL %s actual=%0h expected=%0h", t, curSeg, v);
            end
          end
        end
      end else if (curN != 0) begin
        nChk++;
        nFail++;
        $display("FAIL R13 gap after %0d bytes actual=0 expected=1", curN);
        curN = 0;
      end
    end
  end

  task automatic rxSeg(input logic [15:0] src, dst, input logic [31:0] seq, ack,
      input logic [7:0] flags);
    logic [159:0] v;
    v = mkSeg(src, dst, seq, ack, flags);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      rxValid = 1'b1;
      rxFirst = (i == 0);
      rxData  = v[159 - 8*i -: 8];
    end
    @(negedge clk);
    rxValid = 1'b0;
    rxFirst = 1'b0;
  endtask

  task automatic waitSegs(input int n, input int lim);
    for (int i = 0; i < lim && segCount < n; i++) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic resume(input logic [31:0] s);
    @(negedge clk);
    txResume  = 1'b1;
    resumeSeq = s;
    @(negedge clk);
    txResume  = 1'b0;
  endtask

  initial begin
    logic [159:0] full, noSeq;
    logic [31:0]  iss, iss2;
    full  = '1;
    noSeq = '1;
    noSeq[127:96] = '0;

    idle(5);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk(!txValid && !txInit && !rxInit, "R1 outputs idle", {txValid, txInit, rxInit}, 0);
    chk(tcbPeerPort == 0 && tcbSndNxt == 0 && tcbRcvNxt == 0, "R1 tcb zero",
        tcbSndNxt, 0);

    // R2 non-requests are dropped
    rxSeg(CPORT, LPORT, 32'h1111, 32'h2222, 8'h10);
    rxSeg(CPORT, 16'h0051, 32'h1111, 32'h0, 8'h02);
    rxSeg(CPORT, LPORT, 32'h1111, 32'h0, 8'h12);
    idle(40);
    chk(segCount == 0, "R2 no reply while listening", segCount, 0);

    // R4 hold off until ready, R3 SYN-ACK contents
    txReady = 1'b0;
    expectSeg(mkSeg(LPORT, CPORT, 32'h0, 32'h1000_0001, 8'h12), noSeq, "R3 SYN-ACK");
    rxSeg(CPORT, LPORT, 32'h1000_0000, 32'h0, 8'h02);
    idle(60);
    chk(segCount == 0 && !txValid, "R4 held while not ready", segCount, 0);
    txReady = 1'b1;
    waitSegs(1, 100);
    chk(segCount == 1, "R4 sent after ready", segCount, 1);
    iss = lastSeg[127:96];

    // R5 resend after timeout, wrong ack ignored
    expectSeg(mkSeg(LPORT, CPORT, iss, 32'h1000_0001, 8'h12), full, "R5 SYN-ACK resend");
    idle(SA_TO / 2);
    chk(segCount == 1, "R5 no early resend", segCount, 1);
    waitSegs(2, SA_TO + 100);
    chk(segCount == 2, "R5 resent", segCount, 2);
    rxSeg(CPORT, LPORT, 32'h1000_0001, iss + 32'd5, 8'h10);
    idle(5);
    chk(initCnt == 0, "R5 wrong ack no init", initCnt, 0);

    // R6 good ACK opens the connection
    rxSeg(CPORT, LPORT, 32'h1000_0001, iss + 32'd1, 8'h10);
    idle(5);
    chk(initCnt == 1 && initSplit == 0, "R6 init pulses", initCnt, 1);
    chk(tcbSndNxt == iss + 32'd1, "R6 snd next", tcbSndNxt, iss + 32'd1);
    chk(tcbRcvNxt == 32'h1000_0001, "R6 rcv next", tcbRcvNxt, 32'h1000_0001);
    chk(tcbPeerPort == CPORT, "R6 peer port", tcbPeerPort, CPORT);

    // R7 ignored during hand-off
    rxSeg(CPORT, LPORT, 32'h5, 32'h0, 8'h02);
    rxSeg(CPORT, LPORT, 32'h1000_0001, iss + 32'd1, 8'h11);
    idle(40);
    chk(segCount == 2, "R7 silent during hand-off", segCount, 2);
    chk(tcbRcvNxt == 32'h1000_0001 && tcbSndNxt == iss + 32'd1, "R7 tcb unchanged",
        tcbRcvNxt, 32'h1000_0001);

    // R8 FIN on resume, R9 resend
    expectSeg(mkSeg(LPORT, CPORT, 32'h2000_0100, 32'h1000_0001, 8'h11), full, "R8 FIN");
    expectSeg(mkSeg(LPORT, CPORT, 32'h2000_0100, 32'h1000_0001, 8'h11), full, "R9 FIN resend");
    resume(32'h2000_0100);
    waitSegs(3, 100);
    chk(segCount == 3, "R8 FIN sent", segCount, 3);
    idle(FN_TO / 2);
    chk(segCount == 3, "R9 no early resend", segCount, 3);
    waitSegs(4, FN_TO + 100);
    chk(segCount == 4, "R9 FIN resent", segCount, 4);

    // R10 final ACK to client FIN
    rxSeg(CPORT, LPORT, 32'h1000_0001, 32'h2000_0101, 8'h10);
    idle(10);
    chk(segCount == 4, "R10 no reply to FIN ack", segCount, 4);
    expectSeg(mkSeg(LPORT, CPORT, 32'h2000_0101, 32'h1000_0002, 8'h10), full, "R10 last ACK");
    rxSeg(CPORT, LPORT, 32'h1000_0001, 32'h2000_0101, 8'h11);
    waitSegs(5, 100);
    chk(segCount == 5, "R10 ACK sent", segCount, 5);

    // R11 quiet period then cleared
    chk(tcbRcvNxt == 32'h1000_0002, "R11 kept during wait", tcbRcvNxt, 32'h1000_0002);
    rxSeg(CPORT2, LPORT, 32'h7, 32'h0, 8'h02);
    idle(2 * MSL + 60);
    chk(segCount == 5, "R11 ignored during wait", segCount, 5);
    chk(tcbPeerPort == 0 && tcbSndNxt == 0 && tcbRcvNxt == 0, "R11 cleared",
        tcbSndNxt, 0);

    // second connection, R12 client FIN timeout
    expectSeg(mkSeg(LPORT, CPORT2, 32'h0, 32'h3000_0001, 8'h12), noSeq, "R3 second SYN-ACK");
    rxSeg(CPORT2, LPORT, 32'h3000_0000, 32'h0, 8'h02);
    waitSegs(6, 100);
    iss2 = lastSeg[127:96];
    chk(iss2 != iss, "R3 new initial sequence", iss2, iss + 32'd1);
    rxSeg(CPORT2, LPORT, 32'h3000_0001, iss2 + 32'd1, 8'h10);
    idle(5);
    chk(initCnt == 2 && tcbPeerPort == CPORT2, "R6 second open", initCnt, 2);
    expectSeg(mkSeg(LPORT, CPORT2, 32'h4000_0000, 32'h3000_0001, 8'h11), full, "R8 second FIN");
    resume(32'h4000_0000);
    waitSegs(7, 100);
    rxSeg(CPORT2, LPORT, 32'h3000_0001, 32'h4000_0001, 8'h10);
    idle(CF_TO + 50);
    chk(segCount == 7, "R12 nothing sent on drop", segCount, 7);
    chk(tcbPeerPort == 0 && tcbSndNxt == 0 && tcbRcvNxt == 0, "R12 cleared",
        tcbSndNxt, 0);
    chk(expV.size() == 0, "R13 all expected segments seen", expV.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule